// File: doc/BRIEF.md
# Alarm, Timer and Interrupt Controller

This block sits beside a clock/calendar counter chain and turns its counter values into alarm events, a resolution-selectable BCD timer and a single active-low interrupt line. It holds the control/status byte (location 0x0), the timer byte (location 0x7) and eight alarm bytes (locations 0x8 to 0xF). The byte at 0x8 configures alarms and the timer. Bytes 0x9 to 0xE are compared against the six counter bytes at a fixed offset of eight. Byte 0xF is the timer compare value. A register bus outside this block writes the bytes, and a combinational read port returns them.

The counter chain presents its six current bytes and pulses `cnt_upd` in the first cycle that a new value is shown. It also supplies one tick strobe for each timer resolution. While the alarm-enable bit is clear, the alarm bytes are ordinary storage, and the interrupt line carries a 1 Hz square wave for calibration.

Top module: `alm_irq_ctrl`

## Requirements
- R1: After reset, every stored byte (status, timer, 0x8 to 0xF) is zero and `int_n` is high. With the counters at zero, location 0x0 reads 0x03 because of the indicators in R3.
- R2: Status byte layout: bit0 timer flag, bit1 alarm flag, bit2 alarm enable, bit3 mask, bits5:4 mode (00 and 01 clock, 10 event), bit6 hold, bit7 stop. With alarm enable set, a read returns the byte as written. Writing a flag bit directly sets or clears it.
- R3: With alarm enable clear in a clock mode, status bit0 reads 1 while hundredths < 0x50 and bit1 reads 1 while seconds < 0x30. `int_n` equals bit0, so it is high in the first half of each second. In event mode, `int_n` stays high and the stored bits are read instead.
- R4: With alarm enable clear, bytes 0x8 to 0xF read back as written and have no effect: the timer does not move and no flag is set.
- R5: Byte 0x8 layout: bits2:0 timer source, bit3 timer interrupt enable, bits5:4 alarm kind (01 daily, 10 weekday, 11 dated), bit6 timer alarm enable, bit7 alarm interrupt enable. In a daily alarm, the hundredths, seconds, minutes and hours bytes must equal 0x9 to 0xC bit for bit. The alarm flag is then set one cycle after the `cnt_upd` strobe. The date and month bytes are ignored.
- R6: A weekday alarm needs the daily match and also needs bit[w] of byte 0xE to be 1, where w is bits 7:5 of the weekday/month counter byte.
- R7: A dated alarm compares all six bytes, except for the year bits 7:6 of the year/date byte and the weekday bits 7:5 of the weekday/month byte.
- R8: A match sets the flag only in a cycle that has `cnt_upd`. A match that is held without a strobe sets nothing.
- R9: In event mode, alarm kind 01 compares only the three low counter bytes with bytes 0x9 to 0xB.
- R10: Timer source codes 001 to 101 select `tick_i[0]` to `tick_i[4]`. Each selected tick adds one in BCD. Code 000, an unselected tick or a set stop bit leaves the timer unchanged.
- R11: The timer steps from 0x99 to 0x00 and sets the timer flag on that step. A write to 0x7 loads the timer.
- R12: When the timer alarm is enabled and the timer steps to the value in byte 0xF, the alarm flag is set.
- R13: With alarm enable set, `int_n` is low exactly when a set flag has its interrupt enable set. It goes high again only after software clears that flag.
- R14: Flags stay set until written to 0. A hardware set in the same cycle as a software clear leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Write location |
| wr_data | input | 8 | Write data |
| rd_addr | input | 4 | Read location |
| rd_data | output | 8 | Read data, combinational |
| cnt_upd | input | 1 | Counter bytes just changed |
| cnt_hsec | input | 8 | Hundredths counter (event digits 1:0) |
| cnt_sec | input | 8 | Seconds counter (event digits 3:2) |
| cnt_min | input | 8 | Minutes counter (event digits 5:4) |
| cnt_hour | input | 8 | Hours counter with format bits |
| cnt_yrdate | input | 8 | Year and date counter |
| cnt_wdmon | input | 8 | Weekday and month counter |
| tick_i | input | 5 | Timer tick strobes, one per resolution |
| int_n | output | 1 | Interrupt, active low |

## Verification
A wrong mask or a wrong weekday index shows up as a flag bit at location 0x0 one cycle after the counter strobe that should or should not have matched. It also shows on `int_n` in that same cycle once the interrupt enable is set. A timer that steps wrongly shows on the read port after a single tick. A missed wrap shows in the timer flag on the step from 0x99. The indicator path can be seen on `int_n` as soon as the hundredths byte crosses 0x50.

// File: rtl/alm_pkg.sv
package alm_pkg;
   localparam int BYTE_W = 8;
   localparam int ADDR_W = 4;
   localparam int N_CMP  = 6;
   localparam logic [ADDR_W-1:0] A_CSR  = 4'h0;
   localparam logic [ADDR_W-1:0] A_TMR  = 4'h7;
   localparam logic [ADDR_W-1:0] A_ALM0 = 4'h8;

   typedef enum logic [1:0] {
      AM_NONE = 2'b00, AM_DAILY = 2'b01, AM_WEEKDAY = 2'b10, AM_DATED = 2'b11
   } alarm_kind_e;

   typedef enum logic [1:0] {
      FM_XTAL = 2'b00, FM_MAINS = 2'b01, FM_EVENT = 2'b10, FM_TEST = 2'b11
   } func_mode_e;

   typedef struct packed {
      logic       stop;
      logic       hold;
      func_mode_e mode;
      logic       mask;
      logic       alm_en;
      logic       aflag;
      logic       tflag;
   } csr_t;

   typedef struct packed {
      logic        aie;
      logic        talm_en;
      alarm_kind_e kind;
      logic        tie;
      logic [2:0]  tsrc;
   } acr_t;

   function automatic logic [BYTE_W-1:0] bcd_inc(input logic [BYTE_W-1:0] v);
      logic [3:0] lo, hi;
      lo = (v[3:0] == 4'd9) ? 4'd0 : v[3:0] + 4'd1;
      hi = (v[3:0] == 4'd9) ? v[7:4] + 4'd1 : v[7:4];
      return {hi, lo};
   endfunction
endpackage

// File: rtl/alm_regs.sv
module alm_regs
   import alm_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int N_ALM  = 8
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          wr_en,
   input  logic [ADDR_W-1:0]             wr_addr,
   input  logic [DATA_W-1:0]             wr_data,
   input  logic                          aflag_set,
   input  logic                          tflag_set,
   output csr_t                          csr_o,
   output logic [N_ALM-1:0][DATA_W-1:0]  alm_o
);
   csr_t csr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         csr_q <= '0;
      end else begin
         if (wr_en && wr_addr == A_CSR) csr_q <= csr_t'(wr_data);
         if (aflag_set) csr_q.aflag <= 1'b1;
         if (tflag_set) csr_q.tflag <= 1'b1;
      end
   end
   assign csr_o = csr_q;

   for (genvar k = 0; k < N_ALM; k++) begin : g_alm
      logic [DATA_W-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) q <= '0;
         else if (wr_en && wr_addr == ADDR_W'(int'(A_ALM0) + k)) q <= wr_data;
      end
      assign alm_o[k] = q;
   end
endmodule

// File: rtl/alm_match.sv
module alm_match
   import alm_pkg::*;
(
   input  func_mode_e                    mode,
   input  alarm_kind_e                   kind,
   input  logic [N_CMP-1:0][BYTE_W-1:0]  cnt_v,
   input  logic [N_CMP-1:0][BYTE_W-1:0]  alm_v,
   output logic                          hit_o
);
   localparam int WD_IDX = N_CMP - 1;
   localparam int YD_IDX = N_CMP - 2;

   logic [N_CMP-1:0][BYTE_W-1:0] msk;
   logic [N_CMP-1:0]             eq;
   logic                         valid, day_ok;
   logic [2:0]                   wday;

   assign wday = cnt_v[WD_IDX][7:5];

   always_comb begin
      msk    = '0;
      valid  = 1'b0;
      day_ok = 1'b1;
      if (mode == FM_EVENT) begin
         if (kind == AM_DAILY) begin
            valid = 1'b1;
            for (int k = 0; k < 3; k++) msk[k] = '1;
         end
      end else if (mode != FM_TEST) begin
         if (kind != AM_NONE) begin
            valid = 1'b1;
            for (int k = 0; k < 4; k++) msk[k] = '1;
         end
         if (kind == AM_WEEKDAY)
            day_ok = (wday != 3'd7) && alm_v[WD_IDX][wday];
         if (kind == AM_DATED) begin
            msk[YD_IDX] = 8'h3F;
            msk[WD_IDX] = 8'h1F;
         end
      end
   end

   for (genvar g = 0; g < N_CMP; g++) begin : g_cmp
      assign eq[g] = ((cnt_v[g] ^ alm_v[g]) & msk[g]) == '0;
   end

   assign hit_o = valid & day_ok & (&eq);
endmodule

// File: rtl/alm_timer.sv
module alm_timer
   import alm_pkg::*;
#(
   parameter int               N_RES = 5,
   parameter logic [BYTE_W-1:0] TOP  = 8'h99
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               run,
   input  logic [2:0]         tsrc,
   input  logic [N_RES-1:0]   ticks,
   input  logic               ld,
   input  logic [BYTE_W-1:0]  ld_val,
   input  logic               cmp_en,
   input  logic [BYTE_W-1:0]  cmp_val,
   output logic [BYTE_W-1:0]  tmr_o,
   output logic               wrap_o,
   output logic               hit_o
);
   logic [N_RES-1:0]  sel;
   logic [BYTE_W-1:0] tmr_q, nxt;
   logic              step;

   for (genvar r = 0; r < N_RES; r++) begin : g_src
      assign sel[r] = ticks[r] && (tsrc == 3'(r + 1));
   end

   assign step = run && (|sel) && !ld;
   assign nxt  = (tmr_q == TOP) ? '0 : bcd_inc(tmr_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    tmr_q <= '0;
      else if (ld)   tmr_q <= ld_val;
      else if (step) tmr_q <= nxt;
   end

   assign tmr_o  = tmr_q;
   assign wrap_o = step && (tmr_q == TOP);
   assign hit_o  = step && cmp_en && (nxt == cmp_val);
endmodule

// File: rtl/alm_irq_ctrl.sv
module alm_irq_ctrl
   import alm_pkg::*;
#(
   parameter int                DATA_W  = 8,
   parameter int                N_RES   = 5,
   parameter int                N_ALM   = 8,
   parameter logic [BYTE_W-1:0] TMR_TOP = 8'h99
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [3:0]         wr_addr,
   input  logic [DATA_W-1:0]  wr_data,
   input  logic [3:0]         rd_addr,
   output logic [DATA_W-1:0]  rd_data,
   input  logic               cnt_upd,
   input  logic [DATA_W-1:0]  cnt_hsec,
   input  logic [DATA_W-1:0]  cnt_sec,
   input  logic [DATA_W-1:0]  cnt_min,
   input  logic [DATA_W-1:0]  cnt_hour,
   input  logic [DATA_W-1:0]  cnt_yrdate,
   input  logic [DATA_W-1:0]  cnt_wdmon,
   input  logic [N_RES-1:0]   tick_i,
   output logic               int_n
);
   localparam int CMP_LO = 1;
   localparam int CMP_HI = CMP_LO + N_CMP - 1;
   localparam int TCMP   = N_ALM - 1;

   if (DATA_W != BYTE_W) begin : g_bad_width
      $error("alm_irq_ctrl: DATA_W must be 8 for BCD fields");
   end
   if (N_ALM != N_CMP + 2) begin : g_bad_alm
      $error("alm_irq_ctrl: N_ALM must hold control, six compare bytes and timer compare");
   end
   if (N_RES < 1 || N_RES > 7) begin : g_bad_res
      $error("alm_irq_ctrl: N_RES must fit a 3-bit source code");
   end

   csr_t                          csr;
   acr_t                          acr;
   logic [N_ALM-1:0][DATA_W-1:0]  alm;
   logic [N_CMP-1:0][DATA_W-1:0]  cnt_v;
   logic [DATA_W-1:0]             tmr, csr_b;
   logic aflag_set, tflag_set, clk_hit, tmr_hit, tmr_wrap;
   logic sec_ind, min_ind, show_ind, clk_mode;

   alm_regs #(.DATA_W(DATA_W), .N_ALM(N_ALM)) i_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .aflag_set(aflag_set), .tflag_set(tflag_set), .csr_o(csr), .alm_o(alm));

   assign acr   = csr.alm_en ? acr_t'(alm[0]) : '0;
   assign cnt_v = {cnt_wdmon, cnt_yrdate, cnt_hour, cnt_min, cnt_sec, cnt_hsec};

   alm_match i_match (
      .mode(csr.mode), .kind(acr.kind), .cnt_v(cnt_v),
      .alm_v(alm[CMP_HI:CMP_LO]), .hit_o(clk_hit));

   alm_timer #(.N_RES(N_RES), .TOP(TMR_TOP)) i_timer (
      .clk(clk), .rst_n(rst_n), .run(csr.alm_en && !csr.stop), .tsrc(acr.tsrc),
      .ticks(tick_i), .ld(wr_en && wr_addr == A_TMR), .ld_val(wr_data),
      .cmp_en(acr.talm_en), .cmp_val(alm[TCMP]), .tmr_o(tmr),
      .wrap_o(tmr_wrap), .hit_o(tmr_hit));

   assign aflag_set = (cnt_upd && csr.alm_en && clk_hit) || tmr_hit;
   assign tflag_set = tmr_wrap;

   assign csr_b    = csr;
   assign clk_mode = !csr.mode[1];
   assign sec_ind  = cnt_hsec[7:4] < 4'd5;
   assign min_ind  = cnt_sec[7:4] < 4'd3;
   assign show_ind = !csr.alm_en && clk_mode;

   always_comb begin
      rd_data = '0;
      if (rd_addr == A_CSR)      rd_data = show_ind ? {csr_b[7:2], min_ind, sec_ind} : csr_b;
      else if (rd_addr == A_TMR) rd_data = tmr;
      else if (rd_addr >= A_ALM0) rd_data = alm[rd_addr[2:0]];
   end

   always_comb begin
      if (csr.alm_en) int_n = !((csr.aflag && acr.aie) || (csr.tflag && acr.tie));
      else            int_n = clk_mode ? sec_ind : 1'b1;
   end
endmodule

// File: rtl/alm_irq_ctrl_chk.sv
module alm_irq_ctrl_chk
   import alm_pkg::*;
#(
   parameter logic [BYTE_W-1:0] TOP = 8'h99
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [3:0]        wr_addr,
   input logic [BYTE_W-1:0] cnt_hsec,
   input logic              int_n,
   input csr_t              csr,
   input acr_t              acr,
   input logic [BYTE_W-1:0] tmr
);
   AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (csr.aflag && !(wr_en && wr_addr == A_CSR)) |=> csr.aflag); // R14

   AST_IRQ_SW_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(int_n) && csr.alm_en && $past(csr.alm_en))
      |-> $past(wr_en && (wr_addr == A_CSR || wr_addr == A_ALM0))); // R13

   AST_TMR_BCD: assert property (@(posedge clk) disable iff (!rst_n)
      (tmr[3:0] <= 4'd9) && (tmr[7:4] <= 4'd9)); // R10

   AST_TMR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (acr.tsrc == 3'd0 && !(wr_en && wr_addr == A_TMR)) |=> $stable(tmr)); // R10

   AST_WRAP_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(tmr) == TOP && tmr == '0 && !$past(wr_en && wr_addr == A_TMR)) |-> csr.tflag); // R11

   AST_SQUARE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (!csr.alm_en && !csr.mode[1] && cnt_hsec < 8'h50) |-> int_n); // R3
endmodule

bind alm_irq_ctrl alm_irq_ctrl_chk #(.TOP(TMR_TOP)) i_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .cnt_hsec(cnt_hsec),
   .int_n(int_n), .csr(csr), .acr(acr), .tmr(tmr));

// File: tb/test_alm_irq_ctrl.sv
module test_alm_irq_ctrl;
   logic       clk = 1'b0, rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [3:0] wr_addr = '0, rd_addr = '0;
   logic [7:0] wr_data = '0, rd_data;
   logic       cnt_upd = 1'b0;
   logic [7:0] c_hs = '0, c_s = '0, c_m = '0, c_h = '0, c_yd = '0, c_wm = '0;
   logic [4:0] tick_i = '0;
   logic       int_n;
   int n_chk = 0, n_bad = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   alm_irq_ctrl i_alm_irq_ctrl (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data), .cnt_upd(cnt_upd), .cnt_hsec(c_hs),
      .cnt_sec(c_s), .cnt_min(c_m), .cnt_hour(c_h), .cnt_yrdate(c_yd),
      .cnt_wdmon(c_wm), .tick_i(tick_i), .int_n(int_n));

   task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(logic [3:0] a, logic [7:0] d);
      @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk); wr_en = 1'b0;
   endtask

   task automatic rd(logic [3:0] a, output logic [7:0] d);
      rd_addr = a; #1; d = rd_data;
   endtask

   task automatic rchk(string tag, logic [3:0] a, logic [7:0] exp);
      logic [7:0] d;
      rd(a, d); check(tag, d, exp);
   endtask

   task automatic set_cnt(logic [7:0] hs, s, m, h, yd, wm);
      c_hs = hs; c_s = s; c_m = m; c_h = h; c_yd = yd; c_wm = wm;
   endtask

   task automatic upd(logic [7:0] hs, s, m, h, yd, wm);
      @(negedge clk); set_cnt(hs, s, m, h, yd, wm); cnt_upd = 1'b1;
      @(negedge clk); cnt_upd = 1'b0;
   endtask

   task automatic tick(int k);
      @(negedge clk); tick_i = 5'(1 << k);
      @(negedge clk); tick_i = '0;
   endtask

   task automatic t_reset();
      rchk("R1 csr indicators", 4'h0, 8'h03);
      rchk("R1 timer", 4'h7, 8'h00);
      rchk("R1 alarm ctrl", 4'h8, 8'h00);
      rchk("R1 alarm timer byte", 4'hF, 8'h00);
      check("R1 int_n", {7'd0, int_n}, 8'h01);
   endtask

   task automatic t_square();
      @(negedge clk); c_hs = 8'h49; #1;
      check("R3 int high below 50", {7'd0, int_n}, 8'h01);
      @(negedge clk); c_hs = 8'h50; c_s = 8'h30; #1;
      check("R3 int low at 50", {7'd0, int_n}, 8'h00);
      rchk("R3 indicators clear", 4'h0, 8'h00);
      wr(4'h0, 8'h20);
      check("R3 event mode int high", {7'd0, int_n}, 8'h01);
      rchk("R3 event mode stored bits", 4'h0, 8'h20);
      wr(4'h0, 8'h00);
      set_cnt(0, 0, 0, 0, 0, 0);
   endtask

   task automatic t_ram();
      wr(4'h8, 8'hF1);
      wr(4'hF, 8'h01);
      tick(0);
      rchk("R4 timer frozen", 4'h7, 8'h00);
      rchk("R4 ctrl byte stored", 4'h8, 8'hF1);
      upd(0, 0, 0, 0, 0, 0);
      check("R4 int square wave", {7'd0, int_n}, 8'h01);
      wr(4'h0, 8'h04);
      rchk("R4 no flag latched", 4'h0, 8'h04);
   endtask

   task automatic t_readback();
      wr(4'h0, 8'h4F);
      rchk("R2 csr readback", 4'h0, 8'h4F);
      wr(4'h0, 8'h04);
      rchk("R2 flags cleared", 4'h0, 8'h04);
   endtask

   task automatic t_daily();
      wr(4'h9, 8'h12); wr(4'hA, 8'h34); wr(4'hB, 8'h56); wr(4'hC, 8'h08);
      wr(4'hD, 8'h15); wr(4'hE, 8'h03); wr(4'h8, 8'h10);
      upd(8'h12, 8'h34, 8'h56, 8'h08, 8'h21, 8'h45);
      rchk("R5 daily match", 4'h0, 8'h06);
      check("R13 no irq without enable", {7'd0, int_n}, 8'h01);
      wr(4'h0, 8'h04);
      upd(8'h13, 8'h34, 8'h56, 8'h08, 8'h21, 8'h45);
      rchk("R5 daily miss", 4'h0, 8'h04);
      @(negedge clk); set_cnt(8'h12, 8'h34, 8'h56, 8'h08, 8'h21, 8'h45);
      repeat (3) @(negedge clk);
      rchk("R8 no strobe no flag", 4'h0, 8'h04);
   endtask

   task automatic t_weekday();
      wr(4'hE, 8'h04); wr(4'h8, 8'h20);
      upd(8'h12, 8'h34, 8'h56, 8'h08, 8'h21, 8'h41);
      rchk("R6 enabled weekday", 4'h0, 8'h06);
      wr(4'h0, 8'h04);
      upd(8'h12, 8'h34, 8'h56, 8'h08, 8'h21, 8'h61);
      rchk("R6 disabled weekday", 4'h0, 8'h04);
   endtask

   task automatic t_dated();
      wr(4'hE, 8'h07); wr(4'hD, 8'h15); wr(4'h8, 8'h30);
      upd(8'h12, 8'h34, 8'h56, 8'h08, 8'hD5, 8'hA7);
      rchk("R7 dated ignores year/weekday", 4'h0, 8'h06);
      wr(4'h0, 8'h04);
      upd(8'h12, 8'h34, 8'h56, 8'h08, 8'hD6, 8'hA7);
      rchk("R7 dated date miss", 4'h0, 8'h04);
   endtask

   task automatic t_event();
      wr(4'h8, 8'h10); wr(4'h0, 8'h24);
      upd(8'h12, 8'h34, 8'h56, 8'h99, 8'h00, 8'h00);
      rchk("R9 event low bytes only", 4'h0, 8'h26);
      wr(4'h0, 8'h04);
   endtask

   task automatic t_irq();
      wr(4'h8, 8'h90);
      check("R13 idle high", {7'd0, int_n}, 8'h01);
      upd(8'h12, 8'h34, 8'h56, 8'h08, 8'h21, 8'h45);
      check("R13 alarm irq low", {7'd0, int_n}, 8'h00);
      repeat (4) @(negedge clk);
      check("R14 flag sticky", {7'd0, int_n}, 8'h00);
      wr(4'h0, 8'h04);
      check("R13 release on clear", {7'd0, int_n}, 8'h01);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = 4'h0; wr_data = 8'h04; cnt_upd = 1'b1;
      @(negedge clk); wr_en = 1'b0; cnt_upd = 1'b0;
      rchk("R14 set wins over clear", 4'h0, 8'h06);
      wr(4'h0, 8'h04);
   endtask

   task automatic t_timer();
      wr(4'h8, 8'h02);
      wr(4'h7, 8'h97);
      rchk("R11 timer load", 4'h7, 8'h97);
      tick(0);
      rchk("R10 unselected tick", 4'h7, 8'h97);
      tick(1);
      rchk("R10 seconds tick", 4'h7, 8'h98);
      wr(4'h8, 8'h00);
      tick(1);
      rchk("R10 source 000 idle", 4'h7, 8'h98);
      wr(4'h8, 8'h0A);
      tick(1); tick(1);
      rchk("R11 wrap to 00", 4'h7, 8'h00);
      rchk("R11 timer flag", 4'h0, 8'h05);
      check("R13 timer irq low", {7'd0, int_n}, 8'h00);
      wr(4'h0, 8'h04);
      check("R13 timer irq release", {7'd0, int_n}, 8'h01);
      wr(4'h0, 8'h84);
      tick(1);
      rchk("R10 stop freezes", 4'h7, 8'h00);
      wr(4'h0, 8'h04);
      wr(4'hF, 8'h02); wr(4'h8, 8'h42);
      tick(1);
      rchk("R12 no match yet", 4'h0, 8'h04);
      tick(1);
      rchk("R12 timer alarm", 4'h0, 8'h06);
      wr(4'h0, 8'h04);
      wr(4'h8, 8'h41);
      tick(0);
      rchk("R10 hundredths source", 4'h7, 8'h03);
      wr(4'h8, 8'h45);
      tick(4); tick(3);
      rchk("R10 days source", 4'h7, 8'h04);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   endtask

   initial begin
      #100000;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_square();
      t_ram();
      t_readback();
      t_daily();
      t_weekday();
      t_dated();
      t_event();
      t_irq();
      t_timer();
      finish_run();
   end
endmodule